// File: doc/BRIEF.md
# Window Watchdog Reset Supervisor

This block watches a software heartbeat on a single watchdog input and drives an active-low reset output for a processor. Every falling edge on the heartbeat input restarts a watchdog period counted in clock ticks. A missed heartbeat forces a reset, and in window mode so does a heartbeat that comes too soon. Every reset is stretched to a fixed number of ticks. A power-good input forces reset on its own, and a disable input turns off all watchdog checking.

Two mode inputs choose how a heartbeat is judged. In plain timeout mode any edge before the period runs out is accepted. In window mode the period is split: a closed window comes first and an open window follows. The open window covers half or three quarters of the period. The block also gives one-cycle strobes for faults and for good edges, so a downstream counter can track consecutive failures.

Top module: `wdt_supervisor`

## Requirements
- R1: While `pwr_good_i` is sampled low, `rst_no` is low from the next cycle on. After `pwr_good_i` is sampled high again, `rst_no` stays low for exactly `RST_TICKS` clock edges and then goes high.
- R2: While `rst_ni` is low, `rst_no`, `fault_o` and `good_o` are all low. After `rst_ni` is released with power good, `rst_no` goes high after exactly `RST_TICKS` clock edges.
- R3: While `rst_no` is low the watchdog counter is held at zero, falling edges on `wdi_i` are ignored and neither strobe fires. Counting starts from zero when reset releases.
- R4: `wdi_i` passes a two-flop synchronizer and a falling-edge detector. Its verdict appears on the strobes three cycles after the input falls.
- R5: If no accepted falling edge arrives within `WD_PERIOD` cycles of the counter starting from zero, `fault_o` pulses and `rst_no` goes low in the same cycle. It then stays low for `RST_TICKS` edges.
- R6: An accepted falling edge clears the watchdog counter and starts a new full period, so a heartbeat that keeps arriving in time never causes a reset.
- R7: In window mode (`win_mode_i`=1) the closed window is `WD_PERIOD`/2 counts when `win_sel_i`=0 (open window 50%). It is `WD_PERIOD`/4 counts when `win_sel_i`=1 (open window 75%). An edge seen while the counter is below the closed width is an early fault: `fault_o` pulses and reset is stretched.
- R8: In window mode an edge seen while the counter is at least the closed width is good. This includes an edge exactly on the boundary. `good_o` pulses and `rst_no` stays high.
- R9: In timeout mode (`win_mode_i`=0) every edge before the period runs out is good, including an edge at count `WD_PERIOD`-1.
- R10: While `wd_disable_i` is high, no fault or good strobe is produced and `rst_no` is controlled by `pwr_good_i` alone.
- R11: Each strobe lasts one cycle. The two strobes never fire together, and a reset caused by power-good produces no strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| pwr_good_i | input | 1 | Supply is good; low forces reset |
| wd_disable_i | input | 1 | High turns watchdog checking off |
| win_mode_i | input | 1 | 0 = plain timeout, 1 = window checking |
| win_sel_i | input | 1 | Open window size: 0 = 50%, 1 = 75% |
| wdi_i | input | 1 | Asynchronous heartbeat input, falling edges count |
| rst_no | output | 1 | Active-low supervised reset |
| fault_o | output | 1 | One-cycle strobe on early or late fault |
| good_o | output | 1 | One-cycle strobe on an accepted edge |

## Verification
The assertions assume that `pwr_good_i`, `wd_disable_i` and the mode inputs change synchronously to the clock. They make no assumption about `wdi_i`, which may toggle at any cycle and with any low width. The stimulus changes every input only on the falling clock edge. It gives `wdi_i` low pulses of one to three cycles and gaps that range from under the closed window to past the full period. Directed edges land one count either side of each window boundary and on the last count of the period.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  typedef enum logic [1:0] {
    EV_NONE  = 2'd0,
    EV_GOOD  = 2'd1,
    EV_EARLY = 2'd2,
    EV_LATE  = 2'd3
  } wd_event_e;
endpackage

// File: rtl/wdt_edge_sync.sv
module wdt_edge_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic fall_o
);
  logic [STAGES:0] chain_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) chain_q <= '1;
    else         chain_q <= {chain_q[STAGES-1:0], d_i};
  end

  // last stage is the delayed copy for edge detection
  assign fall_o = chain_q[STAGES] & ~chain_q[STAGES-1];
endmodule

// File: rtl/wdt_window.sv
module wdt_window
  import wdt_pkg::*;
#(
  parameter int unsigned WD_PERIOD = 64,
  parameter int unsigned CNT_W     = $clog2(WD_PERIOD)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             active_i,
  input  logic             fall_i,
  input  logic             win_mode_i,
  input  logic             win_sel_i,
  output wd_event_e        evt_o,
  output logic [CNT_W-1:0] cnt_o
);
  localparam logic [CNT_W-1:0] LAST     = CNT_W'(WD_PERIOD - 1);
  localparam logic [CNT_W-1:0] CW_HALF  = CNT_W'(WD_PERIOD / 2);
  localparam logic [CNT_W-1:0] CW_QUART = CNT_W'(WD_PERIOD / 4);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] closed_w;
  logic             at_last;

  assign closed_w = win_sel_i ? CW_QUART : CW_HALF;
  assign at_last  = (cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                          cnt_q <= '0;
    else if (!active_i || fall_i || at_last) cnt_q <= '0;
    else                                  cnt_q <= cnt_q + 1'b1;
  end

  always_comb begin
    evt_o = EV_NONE;
    if (active_i) begin
      if (fall_i) evt_o = (win_mode_i && cnt_q < closed_w) ? EV_EARLY : EV_GOOD;
      else if (at_last) evt_o = EV_LATE;
    end
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/wdt_reset_stretch.sv
module wdt_reset_stretch #(
  parameter int unsigned RST_TICKS = 32,
  parameter int unsigned CNT_W     = (RST_TICKS > 1) ? $clog2(RST_TICKS) : 1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic force_i,
  output logic hold_o
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(RST_TICKS - 1);

  logic             hold_q;
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hold_q <= 1'b1;
      cnt_q  <= '0;
    end else if (force_i) begin
      hold_q <= 1'b1;
      cnt_q  <= '0;
    end else if (hold_q) begin
      if (cnt_q == LAST) begin
        hold_q <= 1'b0;
        cnt_q  <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign hold_o = hold_q;
endmodule

// File: rtl/wdt_supervisor.sv
module wdt_supervisor
  import wdt_pkg::*;
#(
  parameter int unsigned WD_PERIOD   = 64,
  parameter int unsigned RST_TICKS   = 32,
  parameter int unsigned SYNC_STAGES = 2,
  localparam int unsigned WD_CNT_W   = $clog2(WD_PERIOD)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pwr_good_i,
  input  logic wd_disable_i,
  input  logic win_mode_i,
  input  logic win_sel_i,
  input  logic wdi_i,
  output logic rst_no,
  output logic fault_o,
  output logic good_o
);
  logic                wdi_fall;
  logic                rst_hold;
  logic                wd_active;
  logic                rst_force;
  wd_event_e           wd_evt;
  logic [WD_CNT_W-1:0] wd_cnt;
  logic                fault_q, good_q;

  wdt_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (wdi_i),
    .fall_o(wdi_fall)
  );

  assign wd_active = ~rst_hold & pwr_good_i & ~wd_disable_i;

  wdt_window #(.WD_PERIOD(WD_PERIOD), .CNT_W(WD_CNT_W)) u_win (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .active_i  (wd_active),
    .fall_i    (wdi_fall),
    .win_mode_i(win_mode_i),
    .win_sel_i (win_sel_i),
    .evt_o     (wd_evt),
    .cnt_o     (wd_cnt)
  );

  assign rst_force = ~pwr_good_i | (wd_evt == EV_EARLY) | (wd_evt == EV_LATE);

  wdt_reset_stretch #(.RST_TICKS(RST_TICKS)) u_stretch (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .force_i(rst_force),
    .hold_o (rst_hold)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fault_q <= 1'b0;
      good_q  <= 1'b0;
    end else begin
      fault_q <= (wd_evt == EV_EARLY) || (wd_evt == EV_LATE);
      good_q  <= (wd_evt == EV_GOOD);
    end
  end

  assign rst_no  = ~rst_hold;
  assign fault_o = fault_q;
  assign good_o  = good_q;
endmodule

// File: rtl/wdt_checker.sv
module wdt_checker #(
  parameter int unsigned WD_PERIOD = 64,
  parameter int unsigned CNT_W     = $clog2(WD_PERIOD)
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             pwr_good_i,
  input logic             wd_disable_i,
  input logic             rst_no,
  input logic             fault_o,
  input logic             good_o,
  input logic [CNT_W-1:0] wd_cnt
);
  AST_PG_FORCES_RST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pwr_good_i |=> !rst_no); // R1
  AST_RELEASE_NEEDS_PG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_no) |-> $past(pwr_good_i)); // R1
  AST_NO_STROBE_IN_RST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(!rst_no) |-> (!fault_o && !good_o)); // R3
  AST_CNT_HELD_IN_RST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rst_no && $past(!rst_no)) |-> (wd_cnt == '0)); // R3
  AST_CNT_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wd_cnt <= CNT_W'(WD_PERIOD - 1)); // R5
  AST_FAULT_RESETS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_o |-> !rst_no); // R5
  AST_GOOD_KEEPS_RUN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    good_o |-> rst_no); // R8
  AST_DISABLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(wd_disable_i) |-> (!fault_o && !good_o)); // R10
  AST_STROBE_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(fault_o && good_o)); // R11
  AST_FAULT_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_o |=> !fault_o); // R11
endmodule

bind wdt_supervisor wdt_checker #(.WD_PERIOD(WD_PERIOD)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .pwr_good_i  (pwr_good_i),
  .wd_disable_i(wd_disable_i),
  .rst_no      (rst_no),
  .fault_o     (fault_o),
  .good_o      (good_o),
  .wd_cnt      (wd_cnt)
);

// File: tb/wdt_supervisor_test.sv
module wdt_supervisor_test;
  localparam int P = 32;
  localparam int R = 8;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic pg = 1'b1, dis = 1'b0, mode = 1'b0, sel = 1'b0, wdi = 1'b1;
  logic rst_no, fault_o, good_o;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #2 clk = ~clk;

  wdt_supervisor #(.WD_PERIOD(P), .RST_TICKS(R)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .pwr_good_i(pg), .wd_disable_i(dis),
    .win_mode_i(mode), .win_sel_i(sel), .wdi_i(wdi),
    .rst_no(rst_no), .fault_o(fault_o), .good_o(good_o)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    end
  endtask

  // reference model built from the requirements
  logic [2:0] m_sync;
  bit m_rst, m_f, m_g;
  int m_rc, m_wc;
  bit mf, mact, mearly, mgood, mlate;
  int mcw;
  always @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      m_sync = 3'b111; m_rst = 1; m_rc = 0; m_wc = 0; m_f = 0; m_g = 0;
    end else begin
      mf     = m_sync[2] & ~m_sync[1];
      mact   = !m_rst && pg && !dis;
      mcw    = sel ? P / 4 : P / 2;
      mearly = mact && mf && mode && (m_wc < mcw);
      mgood  = mact && mf && !mearly;
      mlate  = mact && !mf && (m_wc == P - 1);
      if (!mact || mf || m_wc == P - 1) m_wc = 0; else m_wc++;
      if (!pg || mearly || mlate) begin m_rst = 1; m_rc = 0; end
      else if (m_rst) begin
        if (m_rc == R - 1) begin m_rst = 0; m_rc = 0; end else m_rc++;
      end
      m_f = mearly | mlate; m_g = mgood;
      m_sync = {m_sync[1:0], wdi};
    end
  end

  always @(negedge clk) begin
    if (rst_ni) begin
      chk("R1 model rst_no", rst_no, !m_rst);
      chk("R5 R7 model fault_o", fault_o, m_f);
      chk("R8 R9 model good_o", good_o, m_g);
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  task automatic wait_release();
    for (int i = 0; i < 4 * P && !rst_no; i++) @(negedge clk);
  endtask

  // drive an edge seen by the counter at value c (c >= 2), from a negedge after (re)start
  task automatic wd_edge(input int c, output bit pre_g, output bit g, output bit f);
    repeat (c - 2) @(negedge clk);
    wdi = 1'b0;
    @(negedge clk);
    @(negedge clk);
    pre_g = good_o | fault_o;
    wdi = 1'b1;
    @(negedge clk);
    g = good_o; f = fault_o;
  endtask

  initial begin
    int n;
    bit pg_, g, f;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    chk("R2 reset rst_no", rst_no, 0);
    chk("R2 reset fault_o", fault_o, 0);
    chk("R2 reset good_o", good_o, 0);
    rst_ni = 1'b1;
    n = 0;
    while (!rst_no && n < 100) begin @(negedge clk); n++; end
    chk("R2 stretch after rst_ni", n, R);

    // late fault timing
    n = 0;
    while (!fault_o && n < 4 * P) begin @(negedge clk); n++; end
    chk("R5 late fault delay", n, P);
    chk("R5 reset on late fault", rst_no, 0);
    @(negedge clk);
    chk("R11 fault one cycle", fault_o, 0);

    // edges during reset are ignored
    n = 0;
    for (int i = 0; i < R - 2; i++) begin
      wdi = i[0];
      @(negedge clk);
      if (good_o || fault_o) n++;
    end
    wdi = 1'b1;
    chk("R3 no strobe during reset", n, 0);
    wait_release();
    n = 0;
    while (!fault_o && n < 4 * P) begin @(negedge clk); n++; end
    chk("R3 counter restarts from zero", n, P);
    wait_release();

    // timeout mode
    wd_edge(5, pg_, g, f);
    chk("R4 no verdict before 3 cycles", pg_, 0);
    chk("R4 good after sync", g, 1);
    @(negedge clk);
    chk("R11 good one cycle", good_o, 0);
    wd_edge(P - 2, pg_, g, f);
    chk("R9 last count edge good", g, 1);
    chk("R9 rst stays high", rst_no, 1);
    n = 0;
    for (int i = 0; i < 5; i++) begin
      wd_edge(P - 1, pg_, g, f);
      if (!g || f || !rst_no) n++;
    end
    chk("R6 repeated edges keep running", n, 0);

    // window 50%
    mode = 1'b1; sel = 1'b0;
    wd_edge(P / 2, pg_, g, f);
    chk("R8 boundary 50 good", g, 1);
    wd_edge(P / 2 - 1, pg_, g, f);
    chk("R7 early 50 fault", f, 1);
    chk("R7 early 50 reset", rst_no, 0);
    wait_release();
    // window 75%
    sel = 1'b1;
    wd_edge(P / 4, pg_, g, f);
    chk("R8 boundary 75 good", g, 1);
    wd_edge(P - 1, pg_, g, f);
    chk("R8 late open window good", g, 1);
    wd_edge(P / 4 - 1, pg_, g, f);
    chk("R7 early 75 fault", f, 1);
    wait_release();

    // disable
    dis = 1'b1;
    n = 0;
    for (int i = 0; i < 3 * P; i++) begin
      wdi = (i % 7) != 0;
      @(negedge clk);
      if (fault_o || good_o || !rst_no) n++;
    end
    wdi = 1'b1;
    chk("R10 disabled quiet", n, 0);
    pg = 1'b0;
    @(negedge clk);
    chk("R1 R10 pg forces reset", rst_no, 0);
    chk("R11 no strobe on pg", fault_o, 0);
    @(negedge clk);
    pg = 1'b1;
    n = 0;
    while (!rst_no && n < 100) begin @(negedge clk); n++; end
    chk("R1 stretch after pg", n, R);
    dis = 1'b0;

    // random phase, checked by the model
    for (int s = 0; s < 60; s++) begin
      @(negedge clk);
      mode = $urandom % 2;
      sel  = $urandom % 2;
      dis  = ($urandom % 8) == 0;
      for (int e = 0; e < 6; e++) begin
        repeat (1 + $urandom % (P + 4)) @(negedge clk);
        wdi = 1'b0;
        repeat (1 + $urandom % 3) @(negedge clk);
        wdi = 1'b1;
        if ($urandom % 10 == 0) begin
          pg = 1'b0;
          repeat (1 + $urandom % 4) @(negedge clk);
          pg = 1'b1;
        end
      end
    end
    repeat (2 * P) @(negedge clk);
    summary();
    $finish;
  end
endmodule